// File: doc/BRIEF.md
# Masked-Tag Route Range Cache

This block sits in front of a full route-table lookup engine in a packet processor and remembers recent results. A 32-bit destination address comes in on the lookup port, and one cycle later the block reports either a hit with an 8-bit output interface number or a miss. Each stored entry holds a base tag and a mask. One entry therefore covers a whole aligned, power-of-two block of addresses rather than a single host, so a single refill serves every later packet that falls into that block.

The set index is not fixed to the low address bits. The address is first shifted right by a programmed range-size amount. Each of the K index bits is then taken from a programmed position of the shifted address. Offline software chooses those positions so that ranges spread evenly across the sets. The cache has two ways per set, one replacement bit per set, and at most one miss in flight. A miss sends the address to the external lookup engine on a request channel, waits for the response, and writes the returned tag, mask and interface into the set. A single-cycle flush empties the whole cache; this is how the cache stays consistent after route changes.

Top module: `route_range_cache`

## Requirements
- R1: Every lookup accepted (`lk_valid_i` and `lk_ready_o` high at a clock edge) produces `res_valid_o` high in the next cycle, with exactly one of `res_hit_o` or `res_miss_o` high. With no accepted lookup, all three are low in the next cycle.
- R2: A lookup hits when a valid entry in its set satisfies (address AND mask) == (stored tag AND mask). Every address from the base up to base OR NOT mask hits. On a hit, `res_ifc_o` carries the stored interface; on a miss it is 0. If both ways match, way 0 wins.
- R3: The set index is formed as follows. Let S = address >> `cfg_shift_i`. Index bit j equals bit S[p], where p is the 5-bit field `cfg_idx_sel_i[5j+4:5j]`.
- R4: Each set has two ways. A refill writes way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way named by the set's replacement bit. The replacement bit is cleared by reset and by flush. A hit in way w sets it to the other way, and a refill into way w does the same.
- R5: A miss raises `rf_req_valid_o` with `rf_req_addr_o` equal to the lookup address in the next cycle. The request is held stable until `rf_req_ready_i`. `rf_rsp_ready_o` is high only after the request is accepted and until the response is taken. `lk_ready_o` stays low from the cycle after the miss until the cycle after the response handshake.
- R6: On a response handshake, the block stores the returned tag AND mask, the mask and the interface in the set of the missed address. Subsequent lookups in that range hit.
- R7: A high `flush_i` at a clock edge invalidates every entry at that edge. Lookups after it miss.
- R8: If `flush_i` and a response handshake happen at the same edge, the flush wins and nothing is installed. The response is still consumed and the block returns to ready.
- R9: After reset: `lk_ready_o` is 1, `res_valid_o` and `rf_req_valid_o` are 0, and the cache is empty.
- R10: The configuration (`cfg_shift_i`, `cfg_idx_sel_i`) may change only while the cache holds no entries installed since the last reset or flush. Refill masks must be a run of ones from the MSB down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries this cycle |
| cfg_shift_i | input | 5 | Right shift applied before index extraction |
| cfg_idx_sel_i | input | 20 | Four 5-bit bit-position selectors, selector j in bits 5j+4:5j |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_ready_o | output | 1 | Lookup port can accept |
| lk_addr_i | input | 32 | Destination address |
| res_valid_o | output | 1 | Result valid |
| res_hit_o | output | 1 | Result is a hit |
| res_miss_o | output | 1 | Result is a miss |
| res_ifc_o | output | 8 | Output interface on a hit |
| rf_req_valid_o | output | 1 | Refill request valid |
| rf_req_ready_i | input | 1 | Refill request accepted |
| rf_req_addr_o | output | 32 | Address to resolve |
| rf_rsp_valid_i | input | 1 | Refill response valid |
| rf_rsp_ready_o | output | 1 | Block can take the response |
| rf_rsp_tag_i | input | 32 | Range base address |
| rf_rsp_mask_i | input | 32 | Range mask |
| rf_rsp_ifc_i | input | 8 | Interface for the range |

## Verification
Several properties are checked on every cycle:
- the one-cycle result with hit and miss mutually exclusive;
- a miss always opening a refill request;
- the request staying stable until it is accepted;
- the lookup port being closed while a refill is pending;
- a flush leaving no valid entry;
- the single outstanding miss;
- the configuration lock and mask shape.

Other behaviour shows only through the bench's scenarios, which compare against a reference cache model:
- which way a refill displaces;
- that the programmed index positions separate or collide particular ranges;
- that range boundaries hit;
- that a flush coinciding with a response discards it.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
    parameter int ADDR_W = 32;
    parameter int IFC_W  = 8;
    parameter int POS_W  = 5;

    typedef enum logic [1:0] {
        RF_IDLE = 2'd0,
        RF_REQ  = 2'd1,
        RF_WAIT = 2'd2
    } rf_state_e;
endpackage

// File: rtl/rrc_index_sel.sv
module rrc_index_sel #(
    parameter int IDX_K  = 4,
    parameter int ADDR_W = 32,
    parameter int POS_W  = 5
) (
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [POS_W-1:0]       shift_i,
    input  logic [IDX_K*POS_W-1:0] sel_i,
    output logic [IDX_K-1:0]       idx_o
);
    logic [ADDR_W-1:0] shifted;

    assign shifted = addr_i >> shift_i;

    // Each index bit picks one programmed position of the shifted address.
    for (genvar j = 0; j < IDX_K; j++) begin : g_bit
        assign idx_o[j] = shifted[sel_i[j*POS_W +: POS_W]];
    end
endmodule

// File: rtl/rrc_way_match.sv
module rrc_way_match #(
    parameter int ADDR_W = 32
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] tag_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    // Range check via mask-and-compare over the masked prefix bits.
    assign hit_o = valid_i && ((addr_i & mask_i) == (tag_i & mask_i));
endmodule

// File: rtl/rrc_refill_ctrl.sv
module rrc_refill_ctrl
    import rrc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_i,
    input  logic [ADDR_W-1:0] miss_addr_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              rsp_valid_i,
    output logic              rsp_ready_o,
    output logic              busy_o,
    output logic              install_o
);
    typedef struct packed {
        rf_state_e         st;
        logic [ADDR_W-1:0] addr;
    } rf_regs_t;

    rf_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            RF_IDLE: begin
                if (miss_i) begin
                    r_d.st   = RF_REQ;
                    r_d.addr = miss_addr_i;
                end
            end
            RF_REQ: begin
                if (req_ready_i) r_d.st = RF_WAIT;
            end
            RF_WAIT: begin
                if (rsp_valid_i) r_d.st = RF_IDLE;
            end
            default: r_d.st = RF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: RF_IDLE, addr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid_o = (r_q.st == RF_REQ);
    assign req_addr_o  = r_q.addr;
    assign rsp_ready_o = (r_q.st == RF_WAIT);
    assign busy_o      = (r_q.st != RF_IDLE);
    assign install_o   = rsp_valid_i && (r_q.st == RF_WAIT);

    // R5: only one miss in flight; a new miss may only arrive while idle
    a_r5_single_miss: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |-> (r_q.st == RF_IDLE));

    // R5: request held with stable address until accepted
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));
endmodule

// File: rtl/route_range_cache.sv
module route_range_cache
    import rrc_pkg::*;
#(
    parameter int IDX_K = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic [POS_W-1:0]         cfg_shift_i,
    input  logic [IDX_K*POS_W-1:0]   cfg_idx_sel_i,
    input  logic                     lk_valid_i,
    output logic                     lk_ready_o,
    input  logic [ADDR_W-1:0]        lk_addr_i,
    output logic                     res_valid_o,
    output logic                     res_hit_o,
    output logic                     res_miss_o,
    output logic [IFC_W-1:0]         res_ifc_o,
    output logic                     rf_req_valid_o,
    input  logic                     rf_req_ready_i,
    output logic [ADDR_W-1:0]        rf_req_addr_o,
    input  logic                     rf_rsp_valid_i,
    output logic                     rf_rsp_ready_o,
    input  logic [ADDR_W-1:0]        rf_rsp_tag_i,
    input  logic [ADDR_W-1:0]        rf_rsp_mask_i,
    input  logic [IFC_W-1:0]         rf_rsp_ifc_i
);
    localparam int SETS = 1 << IDX_K;
    localparam int NWAY = 2;

    typedef struct packed {
        logic             res_valid;
        logic             res_hit;
        logic             res_miss;
        logic [IFC_W-1:0] res_ifc;
        logic             empty;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NWAY-1:0]   vld_d  [SETS];
    logic [NWAY-1:0]   vld_q  [SETS];
    logic [SETS-1:0]   lru_d, lru_q;
    logic [ADDR_W-1:0] tag_d  [SETS][NWAY];
    logic [ADDR_W-1:0] tag_q  [SETS][NWAY];
    logic [ADDR_W-1:0] mask_d [SETS][NWAY];
    logic [ADDR_W-1:0] mask_q [SETS][NWAY];
    logic [IFC_W-1:0]  ifc_d  [SETS][NWAY];
    logic [IFC_W-1:0]  ifc_q  [SETS][NWAY];

    logic [IDX_K-1:0] lk_idx, fill_idx;
    logic [NWAY-1:0]  way_hit;
    logic             hit_any, hit_w, victim;
    logic             accept, busy, install, any_valid;

    // ---------------------------------------------------------------
    // Index extraction for the lookup address and the pending miss
    // ---------------------------------------------------------------
    rrc_index_sel #(.IDX_K(IDX_K), .ADDR_W(ADDR_W), .POS_W(POS_W)) u_lk_idx (
        .addr_i (lk_addr_i),
        .shift_i(cfg_shift_i),
        .sel_i  (cfg_idx_sel_i),
        .idx_o  (lk_idx)
    );

    rrc_index_sel #(.IDX_K(IDX_K), .ADDR_W(ADDR_W), .POS_W(POS_W)) u_fill_idx (
        .addr_i (rf_req_addr_o),
        .shift_i(cfg_shift_i),
        .sel_i  (cfg_idx_sel_i),
        .idx_o  (fill_idx)
    );

    // ---------------------------------------------------------------
    // Per-way mask-and-compare
    // ---------------------------------------------------------------
    for (genvar w = 0; w < NWAY; w++) begin : g_way
        rrc_way_match #(.ADDR_W(ADDR_W)) u_match (
            .valid_i(vld_q[lk_idx][w]),
            .tag_i  (tag_q[lk_idx][w]),
            .mask_i (mask_q[lk_idx][w]),
            .addr_i (lk_addr_i),
            .hit_o  (way_hit[w])
        );
    end

    assign hit_any = |way_hit;
    assign hit_w   = ~way_hit[0];   // way 0 has priority

    // ---------------------------------------------------------------
    // Refill sequencing
    // ---------------------------------------------------------------
    rrc_refill_ctrl #(.ADDR_W(ADDR_W)) u_refill (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_i     (accept && !hit_any),
        .miss_addr_i(lk_addr_i),
        .req_valid_o(rf_req_valid_o),
        .req_ready_i(rf_req_ready_i),
        .req_addr_o (rf_req_addr_o),
        .rsp_valid_i(rf_rsp_valid_i),
        .rsp_ready_o(rf_rsp_ready_o),
        .busy_o     (busy),
        .install_o  (install)
    );

    assign lk_ready_o = !busy;
    assign accept     = lk_valid_i && lk_ready_o;

    // Invalid way first, then the replacement pointer
    always_comb begin
        if (!vld_q[fill_idx][0])      victim = 1'b0;
        else if (!vld_q[fill_idx][1]) victim = 1'b1;
        else                          victim = lru_q[fill_idx];
    end

    // ---------------------------------------------------------------
    // Next-state computation
    // ---------------------------------------------------------------
    always_comb begin
        vld_d  = vld_q;
        lru_d  = lru_q;
        tag_d  = tag_q;
        mask_d = mask_q;
        ifc_d  = ifc_q;
        ctl_d  = ctl_q;

        ctl_d.res_valid = accept;
        ctl_d.res_hit   = accept && hit_any;
        ctl_d.res_miss  = accept && !hit_any;
        ctl_d.res_ifc   = (accept && hit_any) ? ifc_q[lk_idx][hit_w] : '0;

        if (accept && hit_any) begin
            lru_d[lk_idx] = ~hit_w;
        end

        if (install && !flush_i) begin
            tag_d[fill_idx][victim]  = rf_rsp_tag_i & rf_rsp_mask_i;
            mask_d[fill_idx][victim] = rf_rsp_mask_i;
            ifc_d[fill_idx][victim]  = rf_rsp_ifc_i;
            vld_d[fill_idx][victim]  = 1'b1;
            lru_d[fill_idx]          = ~victim;
            ctl_d.empty              = 1'b0;
        end

        if (flush_i) begin
            for (int s = 0; s < SETS; s++) begin
                vld_d[s] = '0;
            end
            lru_d       = '0;
            ctl_d.empty = 1'b1;
        end
    end

    // ---------------------------------------------------------------
    // Registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{res_valid: 1'b0, res_hit: 1'b0, res_miss: 1'b0,
                       res_ifc: '0, empty: 1'b1};
            lru_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else begin
            ctl_q <= ctl_d;
            lru_q <= lru_d;
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        mask_q <= mask_d;
        ifc_q  <= ifc_d;
    end

    assign res_valid_o = ctl_q.res_valid;
    assign res_hit_o   = ctl_q.res_hit;
    assign res_miss_o  = ctl_q.res_miss;
    assign res_ifc_o   = ctl_q.res_ifc;

    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            any_valid = any_valid | (|vld_q[s]);
        end
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> res_valid_o);

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_hit_o != res_miss_o));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> (!res_hit_o && !res_miss_o));

    a_r2_miss_ifc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss_o |-> (res_ifc_o == '0));

    a_r5_miss_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit_any) |=> (rf_req_valid_o && !lk_ready_o));

    a_r5_port_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req_valid_o || rf_rsp_ready_o) |-> !lk_ready_o);

    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !any_valid);

    a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.empty && !flush_i) |=> ($stable(cfg_shift_i) && $stable(cfg_idx_sel_i)));

    a_r10_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        install |-> (((~rf_rsp_mask_i) & ((~rf_rsp_mask_i) + 32'd1)) == 32'd0));
endmodule

// File: tb/route_range_cache_tb.sv
module route_range_cache_tb;
    localparam int IDX_K = 4;
    localparam int SETS  = 1 << IDX_K;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [4:0]  cfg_shift_i = 5'd8;
    logic [19:0] cfg_idx_sel_i = {5'd23, 5'd22, 5'd21, 5'd20};
    logic        lk_valid_i = 1'b0;
    logic        lk_ready_o;
    logic [31:0] lk_addr_i = '0;
    logic        res_valid_o, res_hit_o, res_miss_o;
    logic [7:0]  res_ifc_o;
    logic        rf_req_valid_o;
    logic        rf_req_ready_i = 1'b0;
    logic [31:0] rf_req_addr_o;
    logic        rf_rsp_valid_i = 1'b0;
    logic        rf_rsp_ready_o;
    logic [31:0] rf_rsp_tag_i = '0, rf_rsp_mask_i = '0;
    logic [7:0]  rf_rsp_ifc_i = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit [1:0]    m_vld [SETS];
    bit          m_lru [SETS];
    logic [31:0] m_tag [SETS][2];
    logic [31:0] m_msk [SETS][2];
    logic [7:0]  m_ifc [SETS][2];
    logic [31:0] pool  [24];

    always #2.5 clk = ~clk;

    route_range_cache #(.IDX_K(IDX_K)) u_dut (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [IDX_K-1:0] b_idx(input logic [31:0] a);
        logic [31:0] s;
        logic [IDX_K-1:0] r;
        s = a >> cfg_shift_i;
        for (int j = 0; j < IDX_K; j++) r[j] = s[cfg_idx_sel_i[j*5 +: 5]];
        return r;
    endfunction

    function automatic logic [31:0] rt_mask(input logic [31:0] a);
        int plen;
        plen = 8 + int'(a[31:28]);
        return 32'hFFFF_FFFF << (32 - plen);
    endfunction

    function automatic logic [7:0] rt_ifc(input logic [31:0] t);
        return t[31:24] ^ t[23:16] ^ t[15:8] ^ 8'h3C;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < SETS; s++) begin
            m_vld[s] = '0;
            m_lru[s] = 1'b0;
        end
    endtask

    task automatic do_lookup(input logic [31:0] a, input string rq, input bit flush_on_fill);
        logic [IDX_K-1:0] s;
        bit eh;
        int ew;
        bit v;
        s  = b_idx(a);
        eh = 1'b0;
        ew = 0;
        for (int w = 0; w < 2; w++) begin
            if (!eh && m_vld[s][w] && ((a & m_msk[s][w]) == m_tag[s][w])) begin
                eh = 1'b1;
                ew = w;
            end
        end
        chk(lk_ready_o == 1'b1, "R5", "ready before lookup", 32'(lk_ready_o), 32'd1);
        lk_valid_i = 1'b1;
        lk_addr_i  = a;
        @(negedge clk);
        lk_valid_i = 1'b0;
        chk(res_valid_o == 1'b1, "R1", "res_valid", 32'(res_valid_o), 32'd1);
        chk(res_hit_o == eh && res_miss_o == !eh, rq, "hit/miss",
            {30'd0, res_hit_o, res_miss_o}, {30'd0, eh, !eh});
        chk(res_ifc_o == (eh ? m_ifc[s][ew] : 8'd0), "R2", "ifc",
            32'(res_ifc_o), 32'(eh ? m_ifc[s][ew] : 8'd0));
        if (eh) begin
            m_lru[s] = (ew == 0);
        end else begin
            chk(rf_req_valid_o && rf_req_addr_o == a, "R5", "refill request",
                rf_req_addr_o, a);
            chk(lk_ready_o == 1'b0, "R5", "ready low on miss", 32'(lk_ready_o), 32'd0);
            @(negedge clk);
            chk(rf_req_valid_o && rf_req_addr_o == a, "R5", "request held", rf_req_addr_o, a);
            rf_req_ready_i = 1'b1;
            @(negedge clk);
            rf_req_ready_i = 1'b0;
            chk(rf_rsp_ready_o && !rf_req_valid_o, "R5", "waiting for response",
                32'(rf_rsp_ready_o), 32'd1);
            repeat (118) @(negedge clk);
            chk(lk_ready_o == 1'b0, "R5", "ready low during refill", 32'(lk_ready_o), 32'd0);
            rf_rsp_valid_i = 1'b1;
            rf_rsp_mask_i  = rt_mask(a);
            rf_rsp_tag_i   = a & rt_mask(a);
            rf_rsp_ifc_i   = rt_ifc(a & rt_mask(a));
            flush_i        = flush_on_fill;
            @(negedge clk);
            rf_rsp_valid_i = 1'b0;
            flush_i        = 1'b0;
            if (flush_on_fill) begin
                model_clear();
            end else begin
                v = !m_vld[s][0] ? 1'b0 : (!m_vld[s][1] ? 1'b1 : m_lru[s]);
                m_tag[s][v] = a & rt_mask(a);
                m_msk[s][v] = rt_mask(a);
                m_ifc[s][v] = rt_ifc(a & rt_mask(a));
                m_vld[s][v] = 1'b1;
                m_lru[s]    = ~v;
            end
            chk(lk_ready_o && !rf_rsp_ready_o, flush_on_fill ? "R8" : "R6",
                "ready after response", 32'(lk_ready_o), 32'd1);
        end
    endtask

    task automatic do_flush(input logic [4:0] sh, input logic [19:0] sel);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i       = 1'b0;
        cfg_shift_i   = sh;
        cfg_idx_sel_i = sel;
        model_clear();
        @(negedge clk);
    endtask

    task automatic rand_phase(input int n, input string rq);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a;
            a = pool[$urandom_range(23, 0)];
            a[7:0] = 8'($urandom);
            do_lookup(a, rq, 1'b0);
        end
    endtask

    initial begin
        logic [31:0] ra;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 24; i++) pool[i] = $urandom;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(lk_ready_o == 1'b1, "R9", "ready after reset", 32'(lk_ready_o), 32'd1);
        chk(!res_valid_o && !rf_req_valid_o && !rf_rsp_ready_o, "R9", "quiet after reset",
            {29'd0, res_valid_o, rf_req_valid_o, rf_rsp_ready_o}, 32'd0);
        // R4 directed: three ranges share one set (top nibble 1)
        do_lookup(32'h1000_0000, "R9", 1'b0);
        do_lookup(32'h1100_0000, "R4", 1'b0);
        do_lookup(32'h1000_0040, "R4", 1'b0);
        do_lookup(32'h1200_0000, "R4", 1'b0);
        do_lookup(32'h1000_1234, "R4", 1'b0);
        do_lookup(32'h1100_0001, "R4", 1'b0);
        // R2 boundaries of range 0x10000000/9
        do_lookup(32'h107F_FFFF, "R2", 1'b0);
        do_lookup(32'h1080_0000, "R2", 1'b0);
        do_lookup(32'h0FFF_FFFF, "R2", 1'b0);
        // R8 flush coincident with response
        do_lookup(32'h2000_0000, "R8", 1'b1);
        do_lookup(32'h2000_0000, "R8", 1'b0);
        do_lookup(32'h2000_0010, "R6", 1'b0);
        // R1 no lookup -> no result
        @(negedge clk);
        chk(!res_valid_o && !res_hit_o && !res_miss_o, "R1", "idle result",
            {29'd0, res_valid_o, res_hit_o, res_miss_o}, 32'd0);
        rand_phase(120, "R6");
        // R7 flush empties everything
        ra = 32'h1000_0000;
        do_flush(5'd8, {5'd23, 5'd22, 5'd21, 5'd20});
        do_lookup(ra, "R7", 1'b0);
        // R3 / R10 reconfigured index: address bits 28..31 shuffled, no shift
        do_flush(5'd0, {5'd30, 5'd29, 5'd31, 5'd28});
        rand_phase(100, "R3");
        // R3 / R10 index from address bits 24..27 via shift of 4
        do_flush(5'd4, {5'd23, 5'd22, 5'd21, 5'd20});
        do_lookup(32'h3300_0000, "R10", 1'b0);
        do_lookup(32'h4300_0000, "R3", 1'b0);
        do_lookup(32'h5300_0000, "R3", 1'b0);
        do_lookup(32'h3300_0000, "R3", 1'b0);
        rand_phase(100, "R3");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule